// File: doc/BRIEF.md
# Chip Correlator Bank with Folded Multiply-Accumulate

This block is the despreading stage of a low-rate direct-sequence receiver. Each time a received chip sample arrives with its strobe, the sample is pushed into a sliding window of chip positions. The window is then correlated against a bank of fixed antipodal reference codes. The block picks the code with the highest correlation and reports its index and its score.

The correlations run on a time-shared multiply-accumulate datapath. A compile-time fold parameter sets how many chip positions each code's accumulators take per cycle. A fold of 1 is fully serial and uses the least logic. A fold equal to the code length finishes the accumulation in a single cycle. Because the codes are antipodal, each product is either the sample or its negation, so no multipliers are needed. A new strobe may only be given while the block is not busy.

Top module: `chip_corr_bank`

## Requirements
- R1: The window holds the last 16 accepted samples. Position 15 holds the newest sample and position 0 the sample accepted 15 strobes earlier. The score of code k is the sum over positions j of +w[j] when chip j of code k is +1, and -w[j] otherwise. Chip j of code k is +1 when the number of ones in (k AND j) is even, and -1 when it is odd.
- R2: The reported symbol index is the code (0 to 15) with the largest score. Equal scores resolve to the lowest index.
- R3: sym_valid rises exactly 16/UNROLL + 2 clock cycles after the cycle in which an accepted chip_valid is sampled.
- R4: sym_valid is high for exactly one cycle per accepted sample.
- R5: busy is high from the cycle after an accepted strobe until the result is presented, and busy is low while sym_valid is high.
- R6: A chip_valid strobe while busy is high is ignored. It does not enter the window and does not change later results.
- R7: A synchronous reset clears the window to zeros and drives busy and sym_valid low.
- R8: Scores are signed 13-bit values. Full-scale inputs (-128 or +127 at every position) are reported without overflow, and every score lies within ±2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_valid | input | 1 | Strobe that qualifies chip_data |
| chip_data | input | 8 | Signed received chip sample |
| busy | output | 1 | High while a correlation is in progress |
| sym_valid | output | 1 | One-cycle pulse that qualifies the symbol outputs |
| sym_index | output | 4 | Index of the best-matching code |
| sym_score | output | 13 | Signed correlation score of that code |

## Verification
Each reference code is fed in turn at +100 per chip, which must give its own index with a peak score of 1600. Each code is also fed negated: the true code then scores lowest, so the others tie at zero and the lowest-index tie rule is exercised. Constant full-scale runs check the accumulator width at both signed extremes. A long pseudo-random sample stream, compared against an arithmetic model after every strobe, catches wrong chip-position alignment and lane mix-ups in the folded sums. Strobes given during busy, and a result taken straight after reset, separate the ignore rule and the cleared window from the normal shifting.

// File: rtl/corr_pkg.sv
package corr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_PICK
    } corr_state_e;

    // Antipodal code chip: 1 means +1, 0 means -1 (even parity of k AND j gives +1)
    function automatic logic code_chip(input int unsigned k, input int unsigned j);
        int unsigned m;
        logic        p;
        m = k & j;
        p = 1'b0;
        for (int b = 0; b < 32; b++) begin
            p = p ^ m[b];
        end
        return ~p;
    endfunction

endpackage

// File: rtl/corr_shift_reg.sv
module corr_shift_reg #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic signed [SAMPLE_W-1:0] din,
    output logic signed [SAMPLE_W-1:0] taps [TAPS]
);

    logic signed [SAMPLE_W-1:0] taps_d [TAPS];

    always_comb begin
        taps_d = taps;
        if (shift_en) begin
            for (int j = 0; j < TAPS - 1; j++) begin
                taps_d[j] = taps[j+1];
            end
            taps_d[TAPS-1] = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS; j++) begin
                taps[j] <= '0;
            end
        end else begin
            taps <= taps_d;
        end
    end

endmodule

// File: rtl/corr_lane_mac.sv
module corr_lane_mac
    import corr_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int TAPS      = 16,
    parameter int NUM_CODES = 16,
    parameter int UNROLL    = 1,
    parameter int ACC_W     = 13,
    parameter int STEP_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       acc_en,
    input  logic [STEP_W-1:0]          step,
    input  logic signed [SAMPLE_W-1:0] taps  [TAPS],
    output logic signed [ACC_W-1:0]    total [NUM_CODES]
);

    localparam int STEPS = TAPS / UNROLL;

    logic signed [ACC_W-1:0] part_q [NUM_CODES][UNROLL];
    logic signed [ACC_W-1:0] part_d [NUM_CODES][UNROLL];
    logic signed [ACC_W-1:0] term;

    always_comb begin
        part_d = part_q;
        term   = '0;
        if (clr) begin
            for (int c = 0; c < NUM_CODES; c++) begin
                for (int u = 0; u < UNROLL; u++) begin
                    part_d[c][u] = '0;
                end
            end
        end else if (acc_en) begin
            for (int c = 0; c < NUM_CODES; c++) begin
                for (int u = 0; u < UNROLL; u++) begin
                    term = '0;
                    for (int s = 0; s < STEPS; s++) begin
                        if (step == STEP_W'(s)) begin
                            term = code_chip(c, s * UNROLL + u)
                                 ?  ACC_W'(taps[s*UNROLL+u])
                                 : -ACC_W'(taps[s*UNROLL+u]);
                        end
                    end
                    part_d[c][u] = part_q[c][u] + term;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CODES; c++) begin
                for (int u = 0; u < UNROLL; u++) begin
                    part_q[c][u] <= '0;
                end
            end
        end else begin
            part_q <= part_d;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CODES; c++) begin
            total[c] = '0;
            for (int u = 0; u < UNROLL; u++) begin
                total[c] = total[c] + part_q[c][u];
            end
        end
    end

endmodule

// File: rtl/corr_pick.sv
module corr_pick #(
    parameter int NUM_CODES = 16,
    parameter int ACC_W     = 13,
    parameter int IDX_W     = 4
) (
    input  logic signed [ACC_W-1:0] total [NUM_CODES],
    output logic [IDX_W-1:0]        best_idx,
    output logic signed [ACC_W-1:0] best_val
);

    // Strict greater-than keeps the lowest index on a tie
    always_comb begin
        best_idx = '0;
        best_val = total[0];
        for (int c = 1; c < NUM_CODES; c++) begin
            if (total[c] > best_val) begin
                best_idx = IDX_W'(c);
                best_val = total[c];
            end
        end
    end

endmodule

// File: rtl/chip_corr_bank.sv
module chip_corr_bank
    import corr_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int CODE_LEN  = 16,
    parameter int NUM_CODES = 16,
    parameter int UNROLL    = 1
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          chip_valid,
    input  logic signed [SAMPLE_W-1:0]                    chip_data,
    output logic                                          busy,
    output logic                                          sym_valid,
    output logic [$clog2(NUM_CODES)-1:0]                  sym_index,
    output logic signed [SAMPLE_W+$clog2(CODE_LEN):0]     sym_score
);

    localparam int IDX_W  = $clog2(NUM_CODES);
    localparam int ACC_W  = SAMPLE_W + $clog2(CODE_LEN) + 1;
    localparam int STEPS  = CODE_LEN / UNROLL;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int LAT    = STEPS + 2;
    localparam int LAT_W  = $clog2(LAT + 2) + 1;
    localparam int MAXS   = CODE_LEN * (1 << (SAMPLE_W - 1));

    typedef struct packed {
        corr_state_e             st;
        logic [STEP_W-1:0]       step;
        logic                    busy;
        logic                    vld;
        logic [IDX_W-1:0]        idx;
        logic signed [ACC_W-1:0] score;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                       shift_en;
    logic                       clr;
    logic                       acc_en;
    logic signed [SAMPLE_W-1:0] taps  [CODE_LEN];
    logic signed [ACC_W-1:0]    total [NUM_CODES];
    logic [IDX_W-1:0]           best_idx;
    logic signed [ACC_W-1:0]    best_val;

    corr_shift_reg #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (CODE_LEN)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (chip_data),
        .taps     (taps)
    );

    corr_lane_mac #(
        .SAMPLE_W  (SAMPLE_W),
        .TAPS      (CODE_LEN),
        .NUM_CODES (NUM_CODES),
        .UNROLL    (UNROLL),
        .ACC_W     (ACC_W),
        .STEP_W    (STEP_W)
    ) u_mac (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .acc_en (acc_en),
        .step   (ctl_q.step),
        .taps   (taps),
        .total  (total)
    );

    corr_pick #(
        .NUM_CODES (NUM_CODES),
        .ACC_W     (ACC_W),
        .IDX_W     (IDX_W)
    ) u_pick (
        .total    (total),
        .best_idx (best_idx),
        .best_val (best_val)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        shift_en  = 1'b0;
        clr       = 1'b0;
        acc_en    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (chip_valid) begin
                    shift_en   = 1'b1;
                    clr        = 1'b1;
                    ctl_d.st   = ST_MAC;
                    ctl_d.step = '0;
                    ctl_d.busy = 1'b1;
                end
            end
            ST_MAC: begin
                acc_en = 1'b1;
                if (ctl_q.step == STEP_W'(STEPS - 1)) begin
                    ctl_d.st = ST_PICK;
                end else begin
                    ctl_d.step = ctl_q.step + 1'b1;
                end
            end
            ST_PICK: begin
                ctl_d.vld   = 1'b1;
                ctl_d.idx   = best_idx;
                ctl_d.score = best_val;
                ctl_d.busy  = 1'b0;
                ctl_d.st    = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, step: '0, busy: 1'b0, vld: 1'b0, idx: '0, score: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = ctl_q.busy;
    assign sym_valid = ctl_q.vld;
    assign sym_index = ctl_q.idx;
    assign sym_score = ctl_q.score;

    // Latency observer: counts cycles from an accepted strobe
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (chip_valid && !busy) begin
            lat_q <= LAT_W'(1);
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (lat_q == LAT_W'(LAT))); // R3

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid); // R4

    AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> !busy); // R5

    AST_STROBE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (chip_valid && !busy) |=> busy); // R5

    AST_SCORE_BOUND: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> ((sym_score <= MAXS) && (sym_score >= -MAXS))); // R8

endmodule

// File: tb/sim_chip_corr_bank.sv
module sim_chip_corr_bank;

    localparam int W     = 8;
    localparam int N     = 16;
    localparam int NC    = 16;
    localparam int U     = 4;
    localparam int LAT   = N / U + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              chip_valid = 1'b0;
    logic signed [7:0] chip_data = '0;
    logic              busy;
    logic              sym_valid;
    logic [3:0]        sym_index;
    logic signed [12:0] sym_score;

    int n_chk  = 0;
    int n_fail = 0;
    int win [N];

    always #10 clk = ~clk;

    chip_corr_bank #(
        .SAMPLE_W  (W),
        .CODE_LEN  (N),
        .NUM_CODES (NC),
        .UNROLL    (U)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .chip_valid (chip_valid),
        .chip_data  (chip_data),
        .busy       (busy),
        .sym_valid  (sym_valid),
        .sym_index  (sym_index),
        .sym_score  (sym_score)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int chip_sign(input int k, input int j);
        return ($countones(k & j) % 2 == 0) ? 1 : -1;
    endfunction

    function automatic int model_score(input int k);
        int s = 0;
        for (int j = 0; j < N; j++) s += chip_sign(k, j) * win[j];
        return s;
    endfunction

    function automatic int model_idx();
        int bi = 0;
        int bv = model_score(0);
        for (int k = 1; k < NC; k++) begin
            if (model_score(k) > bv) begin
                bv = model_score(k);
                bi = k;
            end
        end
        return bi;
    endfunction

    task automatic push_model(input int s);
        for (int j = 0; j < N - 1; j++) win[j] = win[j+1];
        win[N-1] = s;
    endtask

    // Strobe one sample (optionally a second one while busy), wait for result, compare
    task automatic send(input int s, input bool_extra, input int extra, input string req);
        int cnt;
        chip_valid = 1'b1;
        chip_data  = 8'(s);
        push_model(s);
        @(negedge clk);
        cnt = 1;
        chk(busy == 1'b1, "R5 busy after strobe", int'(busy), 1);
        if (bool_extra) begin
            chip_valid = 1'b1;          // R6: strobe during busy
            chip_data  = 8'(extra);
        end else begin
            chip_valid = 1'b0;
        end
        @(negedge clk);
        cnt++;
        chip_valid = 1'b0;
        while (!sym_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LAT, "R3 latency", cnt, LAT);
        chk(busy == 1'b0, "R5 busy low at result", int'(busy), 0);
        chk(int'(sym_index) == model_idx(), {req, " index"}, int'(sym_index), model_idx());
        chk(int'(sym_score) == model_score(model_idx()), {req, " score"},
            int'(sym_score), model_score(model_idx()));
    endtask

    initial begin
        for (int j = 0; j < N; j++) win[j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        chk(busy == 1'b0, "R7 busy after reset", int'(busy), 0);
        chk(sym_valid == 1'b0, "R7 valid after reset", int'(sym_valid), 0);
        // R7: window cleared, only the new sample is non-zero
        send(37, 1'b0, 0, "R7 cleared window");
        // R4: one-cycle pulse
        @(negedge clk);
        chk(sym_valid == 1'b0, "R4 pulse width", int'(sym_valid), 0);

        // R1/R2: each code, positive and negated
        for (int k = 0; k < NC; k++) begin
            for (int j = 0; j < N; j++) send(100 * chip_sign(k, j), 1'b0, 0, "R1 code match");
            chk(int'(sym_index) == k, "R2 matched code", int'(sym_index), k);
            chk(int'(sym_score) == 1600, "R1 peak score", int'(sym_score), 1600);
            for (int j = 0; j < N; j++) send(-100 * chip_sign(k, j), 1'b0, 0, "R2 tie lowest");
            chk(int'(sym_index) == ((k == 0) ? 1 : 0), "R2 tie lowest", int'(sym_index),
                (k == 0) ? 1 : 0);
        end

        // R8: full-scale extremes
        for (int j = 0; j < N; j++) send(-128, 1'b0, 0, "R8 negative full scale");
        chk(model_score(0) == -2048, "R8 model sanity", model_score(0), -2048);
        for (int j = 0; j < N; j++) send(127, 1'b0, 0, "R8 positive full scale");
        chk(int'(sym_score) == 2032, "R8 max score", int'(sym_score), 2032);

        // R6: strobes during busy are ignored
        for (int i = 0; i < 20; i++) send(i * 11 - 90, 1'b1, 120 - i, "R6 ignore while busy");

        // R1/R2: pseudo-random sweep
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                send(int'($signed(lfsr[7:0])), 1'b0, 0, "R1 random sweep");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule